// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It reads two 32-bit words from memory in sequence. The first is an entry of a page directory, which is found from a base register. The second is an entry of the page table that the first entry names. The physical address is the frame from the second entry joined to the 12-bit page offset. When paging is off, the linear address passes through unchanged and no memory is read. Paging switched on while protection is off is an illegal mode, and a request made in that mode gets a general-protection fault.

The walker serves one request at a time. It raises `busy` from the cycle after it accepts a request until its one-cycle response pulse ends. Memory reads use a plain request/ready handshake. Every page fault writes the full faulting linear address into a fault-address register, replacing whatever value it held before.

Top module: `pt_walker`

## Requirements
- R1: With `pg_en`=0, an accepted request gives `rsp_valid` in the next cycle, with `rsp_phys` equal to the linear address and `rsp_pf`=`rsp_gp`=0. `mem_req` stays low.
- R2: The first read goes to `{dir_base[31:12], lin[31:22], 2'b00}`. Bits 11:0 of `dir_base` have no effect.
- R3: The second read goes to `{dir_entry[31:12], lin[21:12], 2'b00}`. On success `rsp_phys` = `{tbl_entry[31:12], lin[11:0]}` and `rsp_pf`=0.
- R4: Bit 0 of each entry is the present flag. A directory entry with bit 0 = 0 ends the walk at once with `rsp_pf`=1, and no table read is made. A table entry with bit 0 = 0 also gives `rsp_pf`=1.
- R5: With `pg_en`=1 and `pe_en`=0, a request gets `rsp_valid` with `rsp_gp`=1 in the next cycle. No read is issued and `fault_addr` is unchanged.
- R6: `busy` is high from the cycle after acceptance up to and including the response cycle. `rsp_valid` lasts exactly one cycle. Any `req_valid` seen while `busy` is high is ignored.
- R7: `fault_addr` resets to 0. On each page fault it takes the full 32-bit linear address, overwriting the earlier value even if nothing has read it.
- R8: Once `mem_req` is raised, it stays high with a stable `mem_addr` until a cycle in which `mem_ready` is high. That cycle completes the read, and `mem_rdata` is sampled in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when not busy |
| req_lin | input | 32 | Linear address to translate |
| pg_en | input | 1 | Paging enable |
| pe_en | input | 1 | Protection enable |
| dir_base | input | 32 | Directory base; bits 31:12 used |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_phys | output | 32 | Physical address |
| rsp_pf | output | 1 | Page fault |
| rsp_gp | output | 1 | General-protection fault |
| fault_addr | output | 32 | Last faulting linear address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ready | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
The bypass and illegal-mode results are due one cycle after the accepting edge. A walked result is due one cycle after the edge that completes the final read, and `fault_addr` changes on that same edge. The bench drives inputs on the falling edge and compares every output on the next falling edge. In between, it advances a behavioural model by exactly one rising edge, using the inputs it drove. Memory ready is held back for a random number of cycles, so the expected result cycle moves with each read rather than sitting at a fixed latency.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_lin,
  input  logic        pg_en,
  input  logic        pe_en,
  input  logic [31:0] dir_base,
  output logic        busy,
  output logic        rsp_valid,
  output logic [31:0] rsp_phys,
  output logic        rsp_pf,
  output logic        rsp_gp,
  output logic [31:0] fault_addr,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL, S_DONE} st_t;

  st_t         st;
  logic [31:0] lin_q, addr_q, phys_q, fault_q;
  logic        pf_q, gp_q;
  logic        unused_bits;

  assign unused_bits = ^{dir_base[11:0], mem_rdata[11:1]};
  assign busy       = (st != S_IDLE);
  assign rsp_valid  = (st == S_DONE);
  assign mem_req    = (st == S_DIR) || (st == S_TBL);
  assign mem_addr   = addr_q;
  assign rsp_phys   = phys_q;
  assign rsp_pf     = pf_q;
  assign rsp_gp     = gp_q;
  assign fault_addr = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lin_q   <= '0;
      addr_q  <= '0;
      phys_q  <= '0;
      fault_q <= '0;
      pf_q    <= 1'b0;
      gp_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q <= req_lin;
          pf_q  <= 1'b0;
          gp_q  <= 1'b0;
          if (!pg_en) begin
            phys_q <= req_lin;
            st     <= S_DONE;
          end else if (!pe_en) begin
            gp_q <= 1'b1;
            st   <= S_DONE;
          end else begin
            addr_q <= {dir_base[31:12], req_lin[31:22], 2'b00};
            st     <= S_DIR;
          end
        end
        S_DIR: if (mem_ready) begin
          if (!mem_rdata[0]) begin
            pf_q    <= 1'b1;
            fault_q <= lin_q;
            st      <= S_DONE;
          end else begin
            addr_q <= {mem_rdata[31:12], lin_q[21:12], 2'b00};
            st     <= S_TBL;
          end
        end
        S_TBL: if (mem_ready) begin
          if (!mem_rdata[0]) begin
            pf_q    <= 1'b1;
            fault_q <= lin_q;
          end else begin
            phys_q <= {mem_rdata[31:12], lin_q[11:0]};
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !pg_en) |=> (rsp_valid && !mem_req && rsp_phys == $past(req_lin)));
  a_r5_gp_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && pg_en && !pe_en) |=> (rsp_valid && rsp_gp && $stable(fault_addr)));
  a_r4_dir_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIR && mem_ready && !mem_rdata[0]) |=> (rsp_valid && rsp_pf));
  a_r7_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_pf) |-> (fault_addr == lin_q));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic        pg_en = 1'b0, pe_en = 1'b0;
  logic [31:0] dir_base = 32'h0001_0000;
  logic        busy, rsp_valid, rsp_pf, rsp_gp, mem_req, mem_ready = 1'b0;
  logic [31:0] rsp_phys, fault_addr, mem_addr, mem_rdata;

  always #2.5 clk = ~clk;

  pt_walker u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .pg_en(pg_en), .pe_en(pe_en), .dir_base(dir_base), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_phys(rsp_phys), .rsp_pf(rsp_pf), .rsp_gp(rsp_gp), .fault_addr(fault_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  logic [31:0] mem [int unsigned];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  always_comb mem_rdata = rd(mem_addr);

  function automatic logic [31:0] mk(input int d, input int t, input int o);
    return {d[9:0], t[9:0], o[11:0]};
  endfunction

  int checks = 0, fails = 0, pf_seen = 0, rsp_seen = 0, stall = 0;
  logic [31:0] last_pf_addr = '0;
  logic        distinct_pf = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model state: 0 idle, 1 dir read, 2 table read, 3 result
  int          m_st = 0;
  logic [31:0] m_lin = '0, m_addr = '0, m_phys = '0, m_fault = '0;
  logic        m_pf = 1'b0, m_gp = 1'b0;
  logic [31:0] lins [8];

  initial begin
    mem[32'h0001_0004] = 32'h0002_0067;
    mem[32'h0001_0008] = 32'h0003_0066;
    mem[32'h0001_000C] = 32'h0004_0FFF;
    mem[32'h0002_0014] = 32'h1234_5063;
    mem[32'h0002_0018] = 32'h5555_5FFE;
    mem[32'h0004_0FFC] = 32'hFFFF_F001;
    lins[0] = mk(1, 5, 12'h0A5);
    lins[1] = mk(1, 6, 12'h010);
    lins[2] = mk(2, 5, 12'h123);
    lins[3] = mk(3, 1023, 12'hFFF);
    lins[4] = mk(0, 0, 0);
    lins[5] = mk(1023, 1023, 12'hFFF);
    lins[6] = mk(1, 5, 12'hFFF);
    lins[7] = mk(3, 1023, 0);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      // compare outputs against the model (state after the last rising edge)
      chk(busy == (m_st != 0), "R6 busy", {31'b0, busy}, {31'b0, m_st != 0});
      chk(rsp_valid == (m_st == 3), "R6 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_st == 3});
      chk(mem_req == (m_st == 1 || m_st == 2), "R8 mem_req", {31'b0, mem_req}, {31'b0, m_st == 1 || m_st == 2});
      if (m_st == 1) chk(mem_addr == m_addr, "R2 dir addr", mem_addr, m_addr);
      if (m_st == 2) chk(mem_addr == m_addr, "R3 tbl addr", mem_addr, m_addr);
      chk(fault_addr == m_fault, "R7 fault_addr", fault_addr, m_fault);
      if (m_st == 3) begin
        rsp_seen++;
        chk(rsp_gp == m_gp, "R5 rsp_gp", {31'b0, rsp_gp}, {31'b0, m_gp});
        chk(rsp_pf == m_pf, "R4 rsp_pf", {31'b0, rsp_pf}, {31'b0, m_pf});
        if (!m_pf && !m_gp) chk(rsp_phys == m_phys, "R1/R3 rsp_phys", rsp_phys, m_phys);
        if (m_pf) begin
          pf_seen++;
          if (pf_seen > 1 && m_lin != last_pf_addr) distinct_pf = 1'b1;
          last_pf_addr = m_lin;
        end
      end
      stall = busy ? stall + 1 : 0;
      if (stall > 300) begin
        chk(1'b0, "R6 watchdog", 32'(stall), 32'd300);
        break;
      end

      // drive inputs for the next rising edge
      if (cyc == 3) rst_n = 1'b1;
      req_valid = (cyc > 4) && ($urandom_range(0, 2) == 0);
      req_lin   = (m_st != 0 && $urandom_range(0, 1) == 0) ? $urandom : lins[$urandom_range(0, 7)];
      pg_en     = ($urandom_range(0, 9) != 0);
      pe_en     = ($urandom_range(0, 9) != 0);
      dir_base  = {20'h00010, 12'($urandom)};
      mem_ready = ($urandom_range(0, 2) == 0);

      // advance the model by one rising edge
      if (!rst_n) begin
        m_st = 0; m_fault = '0;
      end else begin
        case (m_st)
          0: if (req_valid) begin
            m_lin = req_lin; m_pf = 1'b0; m_gp = 1'b0; m_st = 3;
            if (!pg_en) m_phys = req_lin;
            else if (!pe_en) m_gp = 1'b1;
            else begin
              m_addr = 32'h0001_0000 + 32'(req_lin[31:22]) * 4;
              m_st = 1;
            end
          end
          1: if (mem_ready) begin
            logic [31:0] d;
            d = rd(m_addr);
            if (!d[0]) begin m_pf = 1'b1; m_fault = m_lin; m_st = 3; end
            else begin m_addr = (d & 32'hFFFF_F000) + 32'(m_lin[21:12]) * 4; m_st = 2; end
          end
          2: if (mem_ready) begin
            logic [31:0] t;
            t = rd(m_addr);
            if (!t[0]) begin m_pf = 1'b1; m_fault = m_lin; end
            else m_phys = (t & 32'hFFFF_F000) | (m_lin & 32'h0000_0FFF);
            m_st = 3;
          end
          default: m_st = 0;
        endcase
      end
    end

    chk(rsp_seen > 50, "R6 responses seen", 32'(rsp_seen), 32'd50);
    chk(distinct_pf, "R7 overwrite by later fault", {31'b0, distinct_pf}, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule